// File: doc/BRIEF.md
# Decode-Stage Next-PC Unit with One Delay Slot

This block owns the program counter and the fetch/decode pipeline register of a five-stage, 32-bit-instruction pipeline. It resolves every change of control flow while the instruction is in decode. It looks at the decoding instruction and recognises the two compare-and-branch forms, the two absolute jumps (plain and linking) and the register-indirect jump. It computes the candidate targets and loads the chosen one into the PC at the end of that decode cycle.

The architecture uses a single delay slot. While a control instruction sits in decode, the instruction after it is already being fetched. That instruction is always passed on into decode and executed; nothing is squashed. Branch conditions compare the two source operands taken from the decode-stage forwarding multiplexers, which the surrounding pipeline supplies. The instruction memory read data, the forwarded operands and a hazard stall come in as inputs. The block drives the fetch address, the decode-stage instruction and its PC+4, the selected next PC with a 2-bit source code, and the return address and register-31 override used by the linking jump.

Top module: `dslot_npc_unit`

## Requirements
- R1: While reset is asserted, the fetch PC equals RESET_PC (default 0). The decode instruction register holds all zeros, which acts as a no-op, and the PC-source code is 2'b00.
- R2: When decode holds no taken control transfer, the next PC is the fetch PC plus 4 and the source code is 2'b00.
- R3: The instruction fetched during the decode cycle of a branch or jump (the one at its address plus 4) is always loaded into the decode register on the next unstalled edge. It is never replaced or flushed.
- R4: Opcode 6'h04 branches when the two forwarded operands match in all bits. Opcode 6'h05 branches when they differ in any bit. A taken branch gives source code 2'b01 and target = decode PC+4 + (sign-extended 16-bit immediate << 2), and backward offsets are included.
- R5: Opcodes 6'h02 and 6'h03 give source code 2'b11 and target = {upper 4 bits of decode PC+4, 26-bit index, 2'b00}.
- R6: Opcode 6'h00 with function field 6'h08 gives source code 2'b10, and the next PC is the first forwarded operand (the rs value).
- R7: The linking jump (opcode 6'h03) drives a return address equal to its own address plus 8 and raises the register-31 override. The override is low for every other instruction.
- R8: While the stall input is high, the fetch PC and the decode register hold their values. A pending redirect is not lost and takes effect on the first edge where stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold PC and decode register this cycle |
| imem_rdata_i | input | 32 | Instruction read at fetch_pc_o |
| opnd_a_i | input | XLEN | Forwarded rs operand for the decode instruction |
| opnd_b_i | input | XLEN | Forwarded rt operand for the decode instruction |
| fetch_pc_o | output | PC_W | Current fetch address |
| id_instr_o | output | 32 | Instruction in decode |
| id_pc4_o | output | PC_W | Address of the decode instruction plus 4 |
| next_pc_o | output | PC_W | Selected value for the PC at the next edge |
| pc_src_o | output | 2 | 00 sequential, 01 branch, 10 register, 11 jump |
| link_addr_o | output | PC_W | Return address for the linking jump |
| link_to_r31_o | output | 1 | Force destination register to 31 |

## Verification
The hardest case is a stall that arrives while a taken redirect is waiting in decode. Two things must hold together: the delay-slot instruction already fetched has to survive in the pipeline, and the held redirect must still reach the PC afterwards. The bench runs a short program from a behavioural instruction ROM and raises the stall for two cycles in two places: once while a taken branch-on-different sits in decode, and once while the linking jump does. The scoreboard expects the same fetch address sequence as an unstalled run. Equal and unequal operand pairs that differ only in the lowest bit, together with a backward branch that closes into a loop, cover the compare and the sign extension.

// File: rtl/dslot_npc_pkg.sv
package dslot_npc_pkg;

   localparam logic [5:0] OP_SPECIAL = 6'h00;
   localparam logic [5:0] OP_JUMP    = 6'h02;
   localparam logic [5:0] OP_JLINK   = 6'h03;
   localparam logic [5:0] OP_BR_EQ   = 6'h04;
   localparam logic [5:0] OP_BR_NE   = 6'h05;
   localparam logic [5:0] FN_JREG    = 6'h08;

   localparam int INSN_W = 32;

   typedef enum logic [1:0] {
      SRC_SEQ = 2'b00,
      SRC_BR  = 2'b01,
      SRC_REG = 2'b10,
      SRC_JMP = 2'b11
   } npc_src_e;

   typedef struct packed {
      logic br_eq;
      logic br_ne;
      logic jmp;
      logic jlink;
      logic jreg;
   } ctl_class_t;

endpackage

// File: rtl/dslot_npc_decode.sv
module dslot_npc_decode
   import dslot_npc_pkg::*;
(
   input  logic [5:0] op_i,
   input  logic [5:0] funct_i,
   output ctl_class_t cls_o
);

   always_comb begin
      cls_o = '0;
      unique case (op_i)
         OP_BR_EQ:   cls_o.br_eq = 1'b1;
         OP_BR_NE:   cls_o.br_ne = 1'b1;
         OP_JUMP:    cls_o.jmp   = 1'b1;
         OP_JLINK:   cls_o.jlink = 1'b1;
         OP_SPECIAL: cls_o.jreg  = (funct_i == FN_JREG);
         default:    cls_o = '0;
      endcase
   end

endmodule

// File: rtl/dslot_npc_eq.sv
module dslot_npc_eq #(
   parameter int XLEN     = 32,
   parameter int EQ_CHUNK = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o
);

   localparam int N_CHUNK = XLEN / EQ_CHUNK;

   generate
      if (EQ_CHUNK == XLEN) begin : g_flat
         assign eq_o = ~|(a_i ^ b_i);
      end else begin : g_chunked
         logic [N_CHUNK-1:0] part_eq;
         for (genvar c = 0; c < N_CHUNK; c++) begin : g_part
            assign part_eq[c] = ~|(a_i[c*EQ_CHUNK +: EQ_CHUNK] ^ b_i[c*EQ_CHUNK +: EQ_CHUNK]);
         end
         assign eq_o = &part_eq;
      end
   endgenerate

endmodule

// File: rtl/dslot_npc_target.sv
module dslot_npc_target #(
   parameter int PC_W = 32,
   parameter int XLEN = 32
) (
   input  logic [PC_W-1:0] id_pc4_i,
   input  logic [15:0]     imm_i,
   input  logic [25:0]     index_i,
   input  logic [XLEN-1:0] rs_val_i,
   output logic [PC_W-1:0] br_tgt_o,
   output logic [PC_W-1:0] jmp_tgt_o,
   output logic [PC_W-1:0] reg_tgt_o,
   output logic [PC_W-1:0] link_o
);

   localparam int SEXT_W = PC_W - 18;
   localparam int HIGH_W = PC_W - 28;

   logic [PC_W-1:0] offset;

   assign offset    = {{SEXT_W{imm_i[15]}}, imm_i, 2'b00};
   assign br_tgt_o  = id_pc4_i + offset;
   assign jmp_tgt_o = {id_pc4_i[PC_W-1 -: HIGH_W], index_i, 2'b00};
   assign link_o    = id_pc4_i + PC_W'(4);

   generate
      if (XLEN == PC_W) begin : g_same
         assign reg_tgt_o = rs_val_i;
      end else begin : g_trunc
         assign reg_tgt_o = rs_val_i[PC_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dslot_npc_select.sv
module dslot_npc_select
   import dslot_npc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  ctl_class_t      cls_i,
   input  logic            eq_i,
   input  logic [PC_W-1:0] seq_pc_i,
   input  logic [PC_W-1:0] br_tgt_i,
   input  logic [PC_W-1:0] jmp_tgt_i,
   input  logic [PC_W-1:0] reg_tgt_i,
   output npc_src_e        src_o,
   output logic [PC_W-1:0] next_pc_o
);

   logic take_br;

   assign take_br = (cls_i.br_eq & eq_i) | (cls_i.br_ne & ~eq_i);

   always_comb begin
      if (cls_i.jmp | cls_i.jlink)  src_o = SRC_JMP;
      else if (cls_i.jreg)          src_o = SRC_REG;
      else if (take_br)             src_o = SRC_BR;
      else                          src_o = SRC_SEQ;
   end

   always_comb begin
      unique case (src_o)
         SRC_BR:  next_pc_o = br_tgt_i;
         SRC_REG: next_pc_o = reg_tgt_i;
         SRC_JMP: next_pc_o = jmp_tgt_i;
         default: next_pc_o = seq_pc_i;
      endcase
   end

endmodule

// File: rtl/dslot_npc_fetch_regs.sv
module dslot_npc_fetch_regs #(
   parameter int          PC_W     = 32,
   parameter int          INSN_W   = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   input  logic [PC_W-1:0]   next_pc_i,
   input  logic [INSN_W-1:0] imem_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [PC_W-1:0]   seq_pc_o,
   output logic [INSN_W-1:0] id_instr_o,
   output logic [PC_W-1:0]   id_pc4_o
);

   localparam logic [PC_W-1:0] PC_INIT = RESET_PC[PC_W-1:0];

   assign seq_pc_o = pc_o + PC_W'(4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o       <= PC_INIT;
         id_instr_o <= '0;
         id_pc4_o   <= PC_INIT;
      end else if (!stall_i) begin
         pc_o       <= next_pc_i;
         id_instr_o <= imem_i;
         id_pc4_o   <= seq_pc_o;
      end
   end

endmodule

// File: rtl/dslot_npc_unit.sv
module dslot_npc_unit
   import dslot_npc_pkg::*;
#(
   parameter int          PC_W     = 32,
   parameter int          XLEN     = 32,
   parameter int          EQ_CHUNK = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall_i,
   input  logic [31:0]     imem_rdata_i,
   input  logic [XLEN-1:0] opnd_a_i,
   input  logic [XLEN-1:0] opnd_b_i,
   output logic [PC_W-1:0] fetch_pc_o,
   output logic [31:0]     id_instr_o,
   output logic [PC_W-1:0] id_pc4_o,
   output logic [PC_W-1:0] next_pc_o,
   output logic [1:0]      pc_src_o,
   output logic [PC_W-1:0] link_addr_o,
   output logic            link_to_r31_o
);

   generate
      if (PC_W < 29 || PC_W > 32) begin : g_bad_pcw
         $error("PC_W must lie in 29..32");
      end
      if (XLEN < PC_W) begin : g_bad_xlen
         $error("XLEN must be at least PC_W");
      end
      if (EQ_CHUNK < 1 || (XLEN % EQ_CHUNK) != 0) begin : g_bad_chunk
         $error("EQ_CHUNK must divide XLEN");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
         $error("RESET_PC must be word aligned");
      end
   endgenerate

   ctl_class_t      cls;
   npc_src_e        src;
   logic            ops_eq;
   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] br_tgt;
   logic [PC_W-1:0] jmp_tgt;
   logic [PC_W-1:0] reg_tgt;

   dslot_npc_fetch_regs #(
      .PC_W    (PC_W),
      .INSN_W  (INSN_W),
      .RESET_PC(RESET_PC)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall_i   (stall_i),
      .next_pc_i (next_pc_o),
      .imem_i    (imem_rdata_i),
      .pc_o      (fetch_pc_o),
      .seq_pc_o  (seq_pc),
      .id_instr_o(id_instr_o),
      .id_pc4_o  (id_pc4_o)
   );

   dslot_npc_decode u_dec (
      .op_i   (id_instr_o[31:26]),
      .funct_i(id_instr_o[5:0]),
      .cls_o  (cls)
   );

   dslot_npc_eq #(
      .XLEN    (XLEN),
      .EQ_CHUNK(EQ_CHUNK)
   ) u_eq (
      .a_i (opnd_a_i),
      .b_i (opnd_b_i),
      .eq_o(ops_eq)
   );

   dslot_npc_target #(
      .PC_W(PC_W),
      .XLEN(XLEN)
   ) u_tgt (
      .id_pc4_i (id_pc4_o),
      .imm_i    (id_instr_o[15:0]),
      .index_i  (id_instr_o[25:0]),
      .rs_val_i (opnd_a_i),
      .br_tgt_o (br_tgt),
      .jmp_tgt_o(jmp_tgt),
      .reg_tgt_o(reg_tgt),
      .link_o   (link_addr_o)
   );

   dslot_npc_select #(
      .PC_W(PC_W)
   ) u_sel (
      .cls_i    (cls),
      .eq_i     (ops_eq),
      .seq_pc_i (seq_pc),
      .br_tgt_i (br_tgt),
      .jmp_tgt_i(jmp_tgt),
      .reg_tgt_i(reg_tgt),
      .src_o    (src),
      .next_pc_o(next_pc_o)
   );

   assign pc_src_o      = src;
   assign link_to_r31_o = cls.jlink;

endmodule

// File: rtl/dslot_npc_chk.sv
module dslot_npc_chk #(
   parameter int          PC_W     = 32,
   parameter int          XLEN     = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            stall_i,
   input logic [XLEN-1:0] opnd_a_i,
   input logic [PC_W-1:0] fetch_pc_o,
   input logic [31:0]     id_instr_o,
   input logic [PC_W-1:0] id_pc4_o,
   input logic [PC_W-1:0] next_pc_o,
   input logic [1:0]      pc_src_o,
   input logic [PC_W-1:0] link_addr_o,
   input logic            link_to_r31_o
);

   assert_reset_pc_R1: assert property (@(posedge clk)
      !rst_n |=> (fetch_pc_o == RESET_PC[PC_W-1:0]));

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && pc_src_o == 2'b00) |=> (fetch_pc_o == $past(fetch_pc_o) + PC_W'(4)));

   assert_delay_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_i |=> (id_pc4_o == $past(fetch_pc_o) + PC_W'(4)));

   assert_redirect_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && pc_src_o != 2'b00) |=> (fetch_pc_o == $past(next_pc_o)));

   assert_branch_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_src_o == 2'b01) |-> (id_instr_o[31:27] == 5'b00010));

   assert_jump_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_src_o == 2'b11) |-> (id_instr_o[31:27] == 5'b00001));

   assert_jreg_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_src_o == 2'b10) |-> (next_pc_o == opnd_a_i[PC_W-1:0]));

   assert_link_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_to_r31_o |-> (pc_src_o == 2'b11 && link_addr_o == id_pc4_o + PC_W'(4)));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> ($stable(fetch_pc_o) && $stable(id_instr_o) && $stable(id_pc4_o)));

endmodule

bind dslot_npc_unit dslot_npc_chk #(
   .PC_W    (PC_W),
   .XLEN    (XLEN),
   .RESET_PC(RESET_PC)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall_i      (stall_i),
   .opnd_a_i     (opnd_a_i),
   .fetch_pc_o   (fetch_pc_o),
   .id_instr_o   (id_instr_o),
   .id_pc4_o     (id_pc4_o),
   .next_pc_o    (next_pc_o),
   .pc_src_o     (pc_src_o),
   .link_addr_o  (link_addr_o),
   .link_to_r31_o(link_to_r31_o)
);

// File: tb/dslot_npc_unit_tb.sv
`timescale 1ns/1ps
module dslot_npc_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall_i = 1'b0;
   logic [31:0] imem_rdata_i;
   logic [31:0] opnd_a_i, opnd_b_i;
   logic [31:0] fetch_pc_o, id_instr_o, id_pc4_o, next_pc_o, link_addr_o;
   logic [1:0]  pc_src_o;
   logic        link_to_r31_o;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   int unsigned exp_q[$];
   bit          mon_en = 1'b0;
   bit          done   = 1'b0;
   logic [31:0] last_pc = 32'h0;
   logic [31:0] last_id = 32'h0;

   always #10 clk = ~clk;

   dslot_npc_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .stall_i      (stall_i),
      .imem_rdata_i (imem_rdata_i),
      .opnd_a_i     (opnd_a_i),
      .opnd_b_i     (opnd_b_i),
      .fetch_pc_o   (fetch_pc_o),
      .id_instr_o   (id_instr_o),
      .id_pc4_o     (id_pc4_o),
      .next_pc_o    (next_pc_o),
      .pc_src_o     (pc_src_o),
      .link_addr_o  (link_addr_o),
      .link_to_r31_o(link_to_r31_o)
   );

   function automatic logic [31:0] rom(input logic [31:0] a);
      case (a)
         32'h04: rom = {6'h04, 5'd1, 5'd1, 16'd3};       // beq r1,r1 taken -> 0x14
         32'h14: rom = {6'h05, 5'd1, 5'd1, 16'd5};       // bne equal, not taken
         32'h1C: rom = {6'h05, 5'd1, 5'd2, 16'd2};       // bne differ, taken -> 0x28
         32'h28: rom = {6'h04, 5'd1, 5'd2, 16'd7};       // beq differ, not taken
         32'h30: rom = {6'h02, 26'h10};                  // j 0x40
         32'h40: rom = {6'h03, 26'h18};                  // jal 0x60
         32'h64: rom = {6'h00, 5'd3, 15'd0, 6'h08};      // jr r3 -> 0x80
         32'h80: rom = {6'h04, 5'd0, 5'd0, 16'hFFFF};    // beq backward loop
         default: rom = {6'h08, 10'd0, a[15:0]};         // filler
      endcase
   endfunction

   function automatic logic [31:0] reg_val(input logic [4:0] r);
      case (r)
         5'd0:    reg_val = 32'h0;
         5'd1:    reg_val = 32'h1234_5678;
         5'd2:    reg_val = 32'h1234_5679;
         5'd3:    reg_val = 32'h80;
         default: reg_val = 32'hDEAD_0000 | 32'(r);
      endcase
   endfunction

   assign imem_rdata_i = rom(fetch_pc_o);
   assign opnd_a_i     = reg_val(id_instr_o[25:21]);
   assign opnd_b_i     = reg_val(id_instr_o[20:16]);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_expected();
      int unsigned seq [20] = '{32'h04, 32'h08, 32'h14, 32'h18, 32'h1C, 32'h20, 32'h28,
                                32'h2C, 32'h30, 32'h34, 32'h40, 32'h44, 32'h60, 32'h64,
                                32'h68, 32'h80, 32'h84, 32'h80, 32'h84, 32'h80};
      foreach (seq[i]) exp_q.push_back(seq[i]);
   endtask

   // monitor: scoreboard compare at falling edge
   always @(negedge clk) begin
      if (mon_en && exp_q.size() > 0) begin
         logic [1:0]  e_src;
         logic [31:0] e_next;
         if (stall_i) begin
            check("R8 pc hold", fetch_pc_o, last_pc);
            check("R8 id hold", id_instr_o, last_id);
         end else begin
            check("R2/R4/R5/R6 fetch sequence", fetch_pc_o, exp_q.pop_front());
            check("R3 delay slot in decode", id_instr_o, rom(last_pc));
         end
         e_src  = 2'b00;
         e_next = fetch_pc_o + 32'd4;
         case (id_pc4_o)
            32'h08: begin e_src = 2'b01; e_next = 32'h14; end
            32'h20: begin e_src = 2'b01; e_next = 32'h28; end
            32'h34: begin e_src = 2'b11; e_next = 32'h40; end
            32'h44: begin e_src = 2'b11; e_next = 32'h60; end
            32'h68: begin e_src = 2'b10; e_next = 32'h80; end
            32'h84: begin e_src = 2'b01; e_next = 32'h80; end
            default: ;
         endcase
         check("R2/R4/R5/R6 pc_src", 32'(pc_src_o), 32'(e_src));
         check("R2/R4/R5/R6 next_pc", next_pc_o, e_next);
         check("R7 r31 override", 32'(link_to_r31_o), (id_pc4_o == 32'h44) ? 32'd1 : 32'd0);
         if (id_pc4_o == 32'h44) check("R7 link value", link_addr_o, 32'h48);
         last_pc = fetch_pc_o;
         last_id = id_instr_o;
      end
   end

   // stall driver: two-cycle holds while a redirect waits in decode
   initial begin
      int hold = 0;
      forever begin
         @(negedge clk);
         #2;
         if (mon_en && (fetch_pc_o == 32'h20 || fetch_pc_o == 32'h44) && hold < 2) begin
            stall_i = 1'b1;
            hold++;
         end else begin
            stall_i = 1'b0;
            if (!(fetch_pc_o == 32'h20 || fetch_pc_o == 32'h44)) hold = 0;
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 2000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 2000", cyc);
            done = 1'b1;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset pc", fetch_pc_o, 32'h0);
      check("R1 reset decode no-op", id_instr_o, 32'h0);
      check("R1 reset pc_src", 32'(pc_src_o), 32'h0);
      push_expected();
      #2 rst_n = 1'b1;
      mon_en = 1'b1;
      while (exp_q.size() > 0 && !done) @(negedge clk);
      #1;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule